// File: doc/BRIEF.md
# Peripheral Clock Divider Bank

This block turns one fast source clock into a set of clock-enable pulses for peripherals. The source first passes through a power-of-two prescaler that produces a "tick" once every 1, 2, 4 or 8 source cycles. A bank of twelve independent dividers counts those ticks. Ten are plain integer dividers. The last two can also add half a tick to their ratio by alternating between two period lengths.

A crossbar places any divider onto any of sixteen output channels, so several channels may share one divider. Each channel is flagged as analog or digital. Analog channels pulse one tick before the digital channels that use the same divider, so analog events settle before digital switching noise begins. All outputs are single-cycle enable pulses synchronous to the source clock. They are not derived clocks.

Configuration is a simple write port of address plus data. Writes set the prescaler exponent, each divider's value and enable, and each channel's routing entry.

Top module: `pclk_divider_bank`

## Requirements
- R1: Writing address 0 sets the prescaler exponent n from wr_data[1:0]. Divider counting then advances once every 2^n source cycles. For a divider of value V, the gap between pulses on a channel is V*2^n source cycles.
- R2: Addresses 1 to 12 configure dividers 0 to 11. The divide value is in wr_data[15:0], the half-step flag in wr_data[16] and the enable in wr_data[17]. A running integer divider of value V pulses once every V ticks.
- R3: Dividers 10 and 11 with the half-step flag set and value N alternate periods of N and N+1 ticks. The first period after enabling is N ticks long, so the gaps measured from the first pulse run N+1, N, N+1, and so on. Dividers 0 to 9 ignore the half-step flag.
- R4: A divide value of 0 behaves as a value of 1: the divider pulses on every tick.
- R5: A new divide value written to a running divider does not shorten the period in progress. It applies from the next terminal count onward.
- R6: A divider whose enable is cleared stops producing pulses on every channel that selects it. It restarts from a fresh count when enabled again.
- R7: Addresses 16 to 31 configure channels 0 to 15. The divider select is in wr_data[3:0] and the analog flag in wr_data[4]. Any number of channels may select the same divider. A select of 12 or more routes no divider, and that channel stays low.
- R8: For one divider, an analog channel pulses exactly 2^n source cycles before the corresponding digital-channel pulse.
- R9: Every output pulse lasts one source cycle. A channel pulses at most once per tick and only in the cycle after a tick.
- R10: A synchronous reset clears the outputs, counters, enables, routing entries and the prescaler exponent. After reset every channel selects divider 0 as digital, and every divider is disabled, so all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration address |
| wr_data | input | 18 | Configuration data |
| pclk_en | output | 16 | Per-channel clock-enable pulses |

## Verification
On every cycle, embedded properties check several things:
- the prescaler never ticks on consecutive cycles while the exponent is steady and non-zero;
- a divider counter never passes its current terminal value;
- a divider that has been stopped for two cycles emits no lagged pulse;
- outputs pulse only in the cycle after a tick and are low right after reset.

The scenarios have to show the rest. These are the exact gap sequences for integer and half-step ratios, the point at which a rewritten value takes hold, the analog lead of one tick, the sharing and unmapped selects of the crossbar, and the clearing effect of a mid-run reset.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

   typedef enum logic [1:0] {
      RGN_PRESCALE,
      RGN_DIVIDER,
      RGN_ROUTE,
      RGN_NONE
   } pdb_region_e;

   // Address map: 0 = prescaler, 1..ndiv = dividers, rbase.. = channel routes
   function automatic pdb_region_e pdb_decode(input int unsigned addr,
                                              input int unsigned ndiv,
                                              input int unsigned rbase,
                                              input int unsigned nout);
      if (addr == 0)                                 return RGN_PRESCALE;
      else if (addr <= ndiv)                         return RGN_DIVIDER;
      else if (addr >= rbase && addr < rbase + nout) return RGN_ROUTE;
      else                                           return RGN_NONE;
   endfunction

endpackage

// File: rtl/pdb_prescaler.sv
module pdb_prescaler #(
   parameter int PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic [PRE_W-1:0] wr_sel,
   output logic             tick
);
   localparam int CNT_W = (1 << PRE_W) - 1;

   if (PRE_W < 1 || PRE_W > 4) begin : g_bad_prew
      $error("pdb_prescaler: PRE_W must be 1..4");
   end

   logic [PRE_W-1:0] psel;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   always_comb mask = CNT_W'((1 << psel) - 1);
   assign tick = ((cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         psel <= '0;
         cnt  <= '0;
      end else begin
         cnt <= cnt + 1'b1;
         if (wr) psel <= wr_sel;
      end
   end

   // R1: a steady non-zero exponent never yields back-to-back ticks
   a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      (tick && $past(tick) && psel == $past(psel)) |-> psel == '0);

endmodule

// File: rtl/pdb_divider.sv
module pdb_divider #(
   parameter int DIV_W = 16,
   parameter bit FRAC  = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tick,
   input  logic           wr,
   input  logic [DIV_W+1:0] wr_data,
   output logic           lead,
   output logic           dig
);
   localparam logic HALF_OK = FRAC;

   logic [DIV_W-1:0] cfg_val, act_val, cnt, last;
   logic             cfg_half, act_half, cfg_en;
   logic             run, lag, phase, tc;

   always_comb begin
      last = (act_val == '0) ? '0 : act_val - 1'b1;
      last = last + DIV_W'(act_half & phase);
   end

   assign tc   = run && tick && (cnt == last);
   assign lead = tc;
   assign dig  = tick && lag;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_val  <= '0;
         cfg_half <= 1'b0;
         cfg_en   <= 1'b0;
         act_val  <= '0;
         act_half <= 1'b0;
         cnt      <= '0;
         run      <= 1'b0;
         lag      <= 1'b0;
      end else begin
         if (wr) begin
            cfg_val  <= wr_data[DIV_W-1:0];
            cfg_half <= wr_data[DIV_W] & HALF_OK;
            cfg_en   <= wr_data[DIV_W+1];
         end
         if (!cfg_en || !run) begin
            run      <= cfg_en;
            cnt      <= '0;
            act_val  <= cfg_val;
            act_half <= cfg_half;
         end else if (tick) begin
            if (tc) begin
               cnt      <= '0;
               act_val  <= cfg_val;
               act_half <= cfg_half;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (!run)      lag <= 1'b0;
         else if (tick) lag <= tc;
      end
   end

   if (FRAC) begin : g_frac
      always_ff @(posedge clk) begin
         if (rst || !run) phase <= 1'b0;
         else if (tc)     phase <= act_half ? ~phase : 1'b0;
      end
   end else begin : g_int
      assign phase = 1'b0;
   end

   // R2: the counter stays inside the active period
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      run |-> cnt <= last);

   // R6: a stopped divider emits no lagged digital pulse
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (!run && !$past(run)) |-> !dig);

endmodule

// File: rtl/pdb_router.sv
module pdb_router #(
   parameter int NUM_DIV = 12,
   parameter int NUM_OUT = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr,
   input  logic [$clog2(NUM_OUT)-1:0] wr_idx,
   input  logic [$clog2(NUM_DIV)-1:0] wr_sel,
   input  logic                       wr_ana,
   input  logic [NUM_DIV-1:0]         lead,
   input  logic [NUM_DIV-1:0]         dig,
   output logic [NUM_OUT-1:0]         pclk_en
);
   localparam int SEL_W = $clog2(NUM_DIV);
   localparam int SLOTS = 1 << SEL_W;

   logic [SEL_W-1:0] sel [NUM_OUT];
   logic             ana [NUM_OUT];
   logic [SLOTS-1:0] lead_pad, dig_pad;

   always_comb begin
      lead_pad = '0;
      dig_pad  = '0;
      lead_pad[NUM_DIV-1:0] = lead;
      dig_pad[NUM_DIV-1:0]  = dig;
   end

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_chan
      always_ff @(posedge clk) begin
         if (rst) begin
            sel[o]     <= '0;
            ana[o]     <= 1'b0;
            pclk_en[o] <= 1'b0;
         end else begin
            if (wr && wr_idx == o) begin
               sel[o] <= wr_sel;
               ana[o] <= wr_ana;
            end
            pclk_en[o] <= (int'(sel[o]) < NUM_DIV) &&
                          (ana[o] ? lead_pad[sel[o]] : dig_pad[sel[o]]);
         end
      end
   end

endmodule

// File: rtl/pclk_divider_bank.sv
module pclk_divider_bank
   import pdb_pkg::*;
#(
   parameter int NUM_DIV    = 12,
   parameter int NUM_FRAC   = 2,
   parameter int NUM_OUT    = 16,
   parameter int DIV_W      = 16,
   parameter int PRE_W      = 2,
   parameter int ADDR_W     = 5,
   parameter int ROUTE_BASE = 16,
   localparam int DATA_W    = DIV_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NUM_OUT-1:0] pclk_en
);
   localparam int SEL_W = $clog2(NUM_DIV);
   localparam int OIX_W = $clog2(NUM_OUT);

   if (NUM_FRAC > NUM_DIV)                        begin : g_bad_frac  $error("NUM_FRAC exceeds NUM_DIV"); end
   if (NUM_DIV + 1 > ROUTE_BASE)                  begin : g_bad_map   $error("divider window overlaps routes"); end
   if (ROUTE_BASE + NUM_OUT > (1 << ADDR_W))      begin : g_bad_addr  $error("routes exceed address space"); end
   if (SEL_W + 1 > DATA_W || PRE_W > DATA_W)      begin : g_bad_data  $error("data word too narrow"); end

   pdb_region_e      rgn;
   logic             pre_tick;
   logic [NUM_DIV-1:0] lead, dig;
   logic [OIX_W-1:0] route_idx;

   always_comb begin
      rgn       = pdb_decode(int'(wr_addr), NUM_DIV, ROUTE_BASE, NUM_OUT);
      route_idx = OIX_W'(int'(wr_addr) - ROUTE_BASE);
   end

   pdb_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst(rst),
      .wr(wr_en && rgn == RGN_PRESCALE),
      .wr_sel(wr_data[PRE_W-1:0]),
      .tick(pre_tick)
   );

   for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
      pdb_divider #(.DIV_W(DIV_W), .FRAC(k >= NUM_DIV - NUM_FRAC)) u_div (
         .clk(clk), .rst(rst), .tick(pre_tick),
         .wr(wr_en && rgn == RGN_DIVIDER && int'(wr_addr) == k + 1),
         .wr_data(wr_data),
         .lead(lead[k]), .dig(dig[k])
      );
   end

   pdb_router #(.NUM_DIV(NUM_DIV), .NUM_OUT(NUM_OUT)) u_route (
      .clk(clk), .rst(rst),
      .wr(wr_en && rgn == RGN_ROUTE),
      .wr_idx(route_idx),
      .wr_sel(wr_data[SEL_W-1:0]),
      .wr_ana(wr_data[SEL_W]),
      .lead(lead), .dig(dig),
      .pclk_en(pclk_en)
   );

   // R10: outputs are low in the first cycle after reset
   a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> pclk_en == '0);

   // R9: a pulse only ever follows a prescaler tick
   a_r9_tick_aligned: assert property (@(posedge clk) disable iff (rst)
      (|pclk_en) |-> $past(pre_tick));

endmodule

// File: tb/pclk_divider_bank_test.sv
module pclk_divider_bank_test;
   localparam int EN   = 1 << 17;
   localparam int HALF = 1 << 16;
   localparam int RB   = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [17:0] wr_data = '0;
   logic [15:0] pclk_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int    exp_q[$];
   int    watch = 0;
   bit    have_last = 0;
   int    last_cyc = 0;
   int    cyc = 0;
   string cur_req = "R2";

   always #4 clk = ~clk;

   pclk_divider_bank uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pclk_en(pclk_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Monitor: measures gaps on the watched channel and pops expectations
   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         if (pclk_en[watch]) begin
            if (have_last && exp_q.size() > 0) begin
               int g;
               g = exp_q.pop_front();
               check(cyc - last_cyc == g, cur_req, cyc - last_cyc, g);
            end
            last_cyc  = cyc;
            have_last = 1;
         end
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 18'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic watch_fresh(input int ch, input string req);
      watch = ch; have_last = 0; cur_req = req;
   endtask

   task automatic push(input int g, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(g);
   endtask

   task automatic drain();
      for (int i = 0; i < 3000 && exp_q.size() > 0; i++) @(negedge clk);
      if (exp_q.size() > 0) begin
         check(0, {cur_req, " missing pulses"}, exp_q.size(), 0);
         exp_q.delete();
      end
   endtask

   task automatic wait_pulse(input int ch);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk); #1;
         if (pclk_en[ch]) return;
      end
      check(0, "pulse timeout", 0, 1);
   endtask

   task automatic quiet(input int ch, input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         if (pclk_en[ch]) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (5) @(negedge clk);
      #1 rst = 1'b0;
      // R10: after reset everything is low
      quiet(0, 20, "R10 reset state ch0");
      @(negedge clk); #1;
      check(pclk_en == '0, "R10 all outputs", int'(pclk_en), 0);

      // R2: integer divide by 4, prescaler n=0, channel 0 digital on divider 0
      wr(RB + 0, 0);
      watch_fresh(0, "R2");
      push(4, 3);
      wr(1, EN | 4);
      drain();

      // R5: rewrite value mid-period, old period finishes first
      wait_pulse(0);
      cur_req = "R5";
      push(4, 1); push(7, 2);
      wr(1, EN | 7);
      drain();

      // R1: prescaler exponent 2, value 7 -> gap 28
      wr(1, 7); repeat (20) @(negedge clk);
      wr(0, 2);
      watch_fresh(0, "R1");
      push(28, 3);
      wr(1, EN | 7);
      drain();

      // R4: value 0 acts as 1, with n=2 and n=0
      wr(1, 0); repeat (20) @(negedge clk);
      watch_fresh(0, "R4 n2");
      push(4, 3);
      wr(1, EN | 0);
      drain();
      wr(1, 0); repeat (20) @(negedge clk);
      wr(0, 0);
      watch_fresh(0, "R4 n0");
      push(1, 5);
      wr(1, EN | 0);
      drain();
      // R9: with n=3 pulses come at most once per tick of 8
      wr(1, 0); repeat (20) @(negedge clk);
      wr(0, 3);
      watch_fresh(0, "R9 n3");
      push(8, 4);
      wr(1, EN | 0);
      drain();
      wr(1, 0); repeat (20) @(negedge clk);
      wr(0, 0);

      // R3: fractional divider 10, value 3 with half-step
      wr(RB + 1, 10);
      watch_fresh(1, "R3 frac");
      push(4, 1); push(3, 1); push(4, 1); push(3, 1);
      wr(11, EN | HALF | 3);
      drain();

      // R3: integer divider 1 ignores half-step
      wr(RB + 2, 1);
      watch_fresh(2, "R3 int ignores half");
      push(3, 4);
      wr(2, EN | HALF | 3);
      drain();

      // R8/R7: n=1, divider 2 value 5 shared by analog ch3 and digital ch4
      wr(0, 1);
      wr(RB + 3, 16 | 2);
      wr(RB + 4, 2);
      wr(RB + 5, 15);
      wr(3, EN | 5);
      for (int p = 0; p < 3; p++) begin
         wait_pulse(3);
         check(pclk_en[4] == 1'b0, "R8 digital not with analog", int'(pclk_en[4]), 0);
         @(negedge clk); #1;
         check(pclk_en[4] == 1'b0 && pclk_en[3] == 1'b0, "R9 single cycle / R8 not early",
               int'({pclk_en[4], pclk_en[3]}), 0);
         @(negedge clk); #1;
         check(pclk_en[4] == 1'b1, "R8 digital two cycles later", int'(pclk_en[4]), 1);
      end
      // R7: unmapped select stays low while shared divider runs
      quiet(5, 60, "R7 unmapped select");

      // R6: disabling stops both channels of divider 2
      wr(3, 5);
      repeat (20) @(negedge clk);
      quiet(3, 60, "R6 disabled analog ch");
      quiet(4, 60, "R6 disabled digital ch");
      // R6: re-enable restarts
      wr(0, 0);
      watch_fresh(4, "R6 restart");
      push(5, 2);
      wr(3, EN | 5);
      drain();

      // R10: mid-run reset clears enables and routing
      wr(RB + 0, 0); wr(1, EN | 0);
      wait_pulse(0);
      rst = 1'b1;
      @(negedge clk); #1;
      rst = 1'b0;
      check(pclk_en == '0, "R10 mid-run reset", int'(pclk_en), 0);
      quiet(0, 40, "R10 divider disabled after reset");
      @(negedge clk); #1;
      check(pclk_en == '0, "R10 routing cleared", int'(pclk_en), 0);

      report();
   end

endmodule